// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block collects 29 single-bit interrupt sources into a 32-bit cause register and gates them with a 32-bit enable mask. It drives one level-sensitive interrupt line toward the processor. Sources sit at cause bits 1 to 29. The timer-0 expiry is at bit 8, DMA channels 0 to 3 are at bits 4 to 7, and the PCI retry timeout is at bit 20. A source bit that goes high at a clock edge sets its cause bit, and the bit then stays set until software clears it.

Three further cause positions are read-only summaries, computed from the latched source bits:
- Bit 0 is the OR of bits 29 to 1.
- Bit 30 is the OR of bits 20 to 1 and bits 29 to 26.
- Bit 31 is the OR of bits 25 to 1.

Software acknowledges one source by writing back the cause value it read, with only that bit at zero. The block also presents the index of the lowest-numbered pending enabled source, so a dispatcher can take the highest-priority source without scanning. The register port is single-cycle: a write takes effect at the clock edge, and reads are combinational on the address.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause register reads 0, the interrupt output is low and the pending-valid output is low.
- R2: A source input `src_i[k-1]` that is high at a rising clock edge sets cause bit k (1 ≤ k ≤ 29). The bit is visible from that edge onward and stays set after the source drops.
- R3: A write to address 0 (cause) clears every source bit written as 0 and leaves every source bit written as 1 unchanged.
- R4: When a source event and a clearing write hit the same cause bit in the same cycle, the bit ends set.
- R5: Writes to cause bits 0, 30 and 31 have no effect; those bits always read as their summaries.
- R6: Cause bit 0 reads as the OR of bits 29..1, bit 30 as the OR of bits 29..26 and 20..1, and bit 31 as the OR of bits 25..1. The mask does not affect these summaries.
- R7: Address 1 is the mask register: all 32 bits are written and read back, and it resets to 0.
- R8: `irq_o` is high exactly while some source bit k in 1..29 has both cause bit k and mask bit k set. It stays high until every such bit is cleared or masked.
- R9: `pend_idx_o` gives the lowest k in 1..29 whose cause and mask bits are both 1, and `pend_valid_o` is high. When no such k exists, `pend_valid_o` is low and `pend_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 29 | Source events; bit k-1 feeds cause bit k |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects cause, 1 selects mask |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Level interrupt toward the processor |
| pend_valid_o | output | 1 | A pending enabled source exists |
| pend_idx_o | output | 5 | Lowest pending enabled source index |

## Verification
Every stored effect — a source pulse, a cause clear, a mask write — appears on `reg_rdata_o`, `irq_o` and the index outputs one clock edge after it is driven. Those outputs are combinational from the registers, so a read is due in the same cycle that the address changes. The bench drives each stimulus on a falling edge and lets exactly one rising edge pass. It then samples on the next falling edge, changing the read address only away from the clock. The same-cycle collision of an event and a clear is driven within a single cycle to hit the one edge where it matters.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int CAUSE_W    = 32;
  localparam int SRC_LO     = 1;
  localparam int SRC_HI     = 29;
  localparam int NUM_SRC    = SRC_HI - SRC_LO + 1;
  localparam int IDX_W      = 5;
  localparam int ADDR_W     = 1;
  localparam int ADDR_CAUSE = 0;
  localparam int ADDR_MASK  = 1;
  // summary positions, decoded by software
  localparam int SUM_ANY    = 0;
  localparam int SUM_LOW    = 30;
  localparam int SUM_MID    = 31;
  // well-known source positions
  localparam int SRC_TIMER0 = 8;
  localparam int SRC_DMA0   = 4;
  localparam int SRC_RETRY  = 20;

  function automatic logic any_in(input logic [CAUSE_W-1:0] v, input int lo, input int hi);
    logic [63:0] sel;
    sel = (64'd1 << (hi - lo + 1)) - 64'd1;
    return |((64'(v) >> lo) & sel);
  endfunction

  // raw has zeros outside the source range
  function automatic logic [CAUSE_W-1:0] with_summary(input logic [CAUSE_W-1:0] raw);
    logic [CAUSE_W-1:0] v;
    v = raw;
    v[SUM_ANY] = any_in(raw, SRC_LO, SRC_HI);
    v[SUM_LOW] = any_in(raw, 26, 29) | any_in(raw, 1, 20);
    v[SUM_MID] = any_in(raw, 1, 25);
    return v;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_src(input logic [CAUSE_W-1:0] pend);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = SRC_HI; i >= SRC_LO; i--)
      if (pend[i]) idx = IDX_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/irq_cause_bits.sv
module irq_cause_bits #(
  parameter int NUM_SRC = 29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] keep_i,
  output logic [NUM_SRC-1:0] bits_o
);
  logic [NUM_SRC-1:0] bits_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q[k] <= 1'b0;
      else if (src_i[k]) bits_q[k] <= 1'b1;
      else if (clr_en && !keep_i[k]) bits_q[k] <= 1'b0;
    end
  end

  assign bits_o = bits_q;

  // R2
  evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_i) |=> ((bits_q & $past(src_i)) == $past(src_i)));
  // R3
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((bits_q & ~$past(keep_i) & ~$past(src_i)) == '0));
  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bits_q & ~$past(bits_q) & ~$past(src_i)) == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_en) mask_q <= wdata;
  end

  assign mask_o = mask_q;

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int W     = 32,
  parameter int IDX_W = 5
) (
  input  logic [W-1:0]     pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  import irq_ctrl_pkg::*;
  logic [W-1:0] pend_src;

  always_comb begin
    pend_src = '0;
    pend_src[SRC_HI:SRC_LO] = pend_i[SRC_HI:SRC_LO];
  end

  assign any_o = |pend_src;
  assign idx_o = lowest_src(pend_src);
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int CW = CAUSE_W,
  parameter int NS = NUM_SRC,
  parameter int IW = IDX_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [CW-1:0] reg_wdata_i,
  output logic [CW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic          pend_valid_o,
  output logic [IW-1:0] pend_idx_o
);
  localparam logic [AW-1:0] A_CAUSE = AW'(ADDR_CAUSE);
  localparam logic [AW-1:0] A_MASK  = AW'(ADDR_MASK);

  logic          wr_cause, wr_mask;
  logic [NS-1:0] src_bits;
  logic [CW-1:0] cause_raw, cause_view, mask_q, pending;

  assign wr_cause = reg_wr_i && (reg_addr_i == A_CAUSE);
  assign wr_mask  = reg_wr_i && (reg_addr_i == A_MASK);

  irq_cause_bits #(.NUM_SRC(NS)) u_bits (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .clr_en(wr_cause), .keep_i(reg_wdata_i[SRC_HI:SRC_LO]),
    .bits_o(src_bits)
  );

  irq_mask_reg #(.W(CW)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mask),
    .wdata(reg_wdata_i), .mask_o(mask_q)
  );

  always_comb begin
    cause_raw = '0;
    cause_raw[SRC_HI:SRC_LO] = src_bits;
  end

  assign cause_view = with_summary(cause_raw);
  assign pending    = cause_raw & mask_q;

  irq_pick #(.W(CW), .IDX_W(IW)) u_pick (
    .pend_i(pending), .any_o(pend_valid_o), .idx_o(pend_idx_o)
  );

  assign irq_o       = |pending;
  assign reg_rdata_o = (reg_addr_i == A_MASK) ? mask_q : cause_view;

  // R6
  sum_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_view[SUM_ANY] == (cause_view[SUM_LOW] | cause_view[SUM_MID]));
  // R8
  irq_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == pend_valid_o);
  // R9
  pick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> pending[pend_idx_o]);
  // R9
  pick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> ((pending & ((CW'(1) << pend_idx_o) - CW'(1))) == '0));
  // R9
  pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid_o |-> (pend_idx_o == '0));
endmodule

// File: tb/irq_cause_ctrl_bench.sv
module irq_cause_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [28:0] src_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [0:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, pend_valid_o;
  logic [4:0]  pend_idx_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_cause_ctrl u_irq_cause_ctrl (.*);

  // src[98:70] mask[69:38] cause[37:6] irq[5] idx[4:0]
  localparam int NV = 6;
  localparam logic [98:0] VEC [NV] = '{
    {29'h0000080, 32'h00000100, 32'hC0000101, 1'b1, 5'd8},
    {29'h0100000, 32'hFFFFFFFF, 32'h80200001, 1'b1, 5'd21},
    {29'h4000000, 32'h00000000, 32'h48000001, 1'b0, 5'd0},
    {29'h0080008, 32'h00100000, 32'hC0100011, 1'b1, 5'd20},
    {29'h10000001, 32'h20000002, 32'hE0000003, 1'b1, 5'd1},
    {29'h0000000, 32'hFFFFFFFF, 32'h00000000, 1'b0, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic pulse(input logic [28:0] s);
    @(negedge clk);
    src_i = s;
    @(negedge clk);
    src_i = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, d); chk("R1 cause", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 valid", {31'b0, pend_valid_o}, 32'h0);
    // R7 mask reset
    rd(1, d); chk("R7 mask reset", d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(0, 32'h0);
      wr(1, VEC[i][69:38]);
      pulse(VEC[i][98:70]);
      rd(0, d); chk("R2 R6 cause view", d, VEC[i][37:6]);
      chk("R8 irq", {31'b0, irq_o}, {31'b0, VEC[i][5]});
      chk("R9 valid", {31'b0, pend_valid_o}, {31'b0, VEC[i][5]});
      chk("R9 idx", {27'b0, pend_idx_o}, {27'b0, VEC[i][4:0]});
    end

    // R3 write-back acknowledge of bit 4 keeps bit 5
    wr(0, 32'h0); wr(1, 32'h0);
    pulse(29'h18);
    wr(0, 32'hFFFFFFEF);
    rd(0, d); chk("R3 ack one bit", d, 32'hC0000021);

    // R4 event on bit 6 while a write clears everything
    @(negedge clk);
    src_i = 29'h20; reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 32'h0;
    @(negedge clk);
    src_i = '0; reg_wr_i = 1'b0;
    rd(0, d); chk("R4 event wins", d, 32'hC0000041);

    // R5 writes to summary positions ignored
    wr(0, 32'h0);
    wr(0, 32'hFFFFFFFF);
    rd(0, d); chk("R5 ones ignored", d, 32'h0);
    wr(0, 32'h0);
    wr(1, 32'h00000040);
    pulse(29'h20);
    wr(0, 32'hFFFFFFFE);
    rd(0, d); chk("R5 bit0 write zero", d, 32'hC0000041);

    // R8 level behaviour
    repeat (3) @(negedge clk);
    chk("R8 irq held", {31'b0, irq_o}, 32'h1);
    wr(1, 32'h0);
    chk("R8 irq masked", {31'b0, irq_o}, 32'h0);
    wr(1, 32'h00000040);
    chk("R8 irq unmasked", {31'b0, irq_o}, 32'h1);
    wr(0, 32'hFFFFFFBF);
    chk("R8 irq cleared", {31'b0, irq_o}, 32'h0);

    // R7 mask readback
    wr(1, 32'hA5A5A5A5);
    rd(1, d); chk("R7 mask readback", d, 32'hA5A5A5A5);

    done = 1;
    summary();
    $finish;
  end
endmodule